// File: doc/BRIEF.md
# Banked Register File with Indirect Access

This block is the data-memory front end of a small 8-bit microcontroller core. The core presents a direct 8-bit address with read and write strobes and write data. The block decodes the address onto a small set of system registers, a bank-0 general RAM, and a bank-1 file of peripheral register stubs. The system registers are two memory pointers, a one-bit bank selector and the accumulator. The block then returns the read data. The accumulator value is also driven onto its own output, so the core's datapath always sees it.

Two reserved direct addresses have no storage. They act as windows through the pointers. The first window always lands in bank 0. The second window lands in whichever bank the selector names. Bank 1 can only be reached through that second window. A pointer that aims at one of the window addresses gives a zero read, and a write through it is dropped. The bank-1 locations are plain storage that peripheral logic will later sit behind.

Top module: `dmem_bank_front`

## Requirements
- R1: A synchronous reset clears pointer 0, pointer 1, the bank selector, the accumulator and every RAM word to 00h.
- R2: Direct addresses 01h, 03h, 04h and 05h select pointer 0, pointer 1, the bank selector and the accumulator. The bank selector stores only bit 0 of a write and reads back as {7'b0, sel}. `acc_out` always shows the accumulator.
- R3: Direct addresses 06h through 7Fh are bank-0 RAM words. Direct addresses 80h through FFh read 00h, and writes to them are ignored.
- R4: Address 00h is a window through pointer 0, and it always uses bank 0, whatever the bank selector holds.
- R5: Address 02h is a window through pointer 1. It uses bank 0 when the selector is 0 and bank 1 when the selector is 1.
- R6: Bank 1 holds storage at 41h through 4Bh. A direct access to one of these addresses reaches the bank-0 word of the same address, never bank 1.
- R7: Inside bank 1, every address other than 01h, 03h, 04h, 05h and 41h–4Bh reads 00h, and writes to it are ignored.
- R8: A window access whose pointer holds 00h or 02h reads 00h, and a write through it changes no state.
- R9: Through either window, pointer values 01h, 03h, 04h and 05h reach the system registers in both banks.
- R10: Reads are combinational, and `rd_data` is 00h while `rd_en` is low. Writes take effect on the rising clock edge, so a read made in the same cycle as a write returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Direct data address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| acc_out | output | 8 | Current accumulator value |

## Verification
The windows are tried with pointer values that fall into bank-0 RAM, bank-1 storage, bank-1 reserved space, the system registers and the window addresses themselves. Each is tried with the selector at 0 and then at 1. This separates the bank-locked window from the bank-following one and shows whether a pointer value is honoured or discarded. Writing the same address through the direct path and through the bank-1 window, each with distinct data, shows whether the two banks are truly separate storage. Range edges (06h, 7Fh, 80h, 40h, 4Bh, 4Ch) check the decoder's bounds. A read and a write on the same cycle checks that the read is combinational and the write lands on the clock edge.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_WIN0 = 8'h00;
    localparam addr_t A_PTR0 = 8'h01;
    localparam addr_t A_WIN1 = 8'h02;
    localparam addr_t A_PTR1 = 8'h03;
    localparam addr_t A_BANK = 8'h04;
    localparam addr_t A_ACC  = 8'h05;
    localparam addr_t A_RAM0_FIRST = 8'h06;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PTR0,
        TGT_PTR1,
        TGT_BANK,
        TGT_ACC,
        TGT_RAM0,
        TGT_RAM1
    } tgt_e;

    typedef struct packed {
        tgt_e  tgt;
        addr_t off;
    } access_t;

    function automatic logic is_window(input addr_t a);
        return (a == A_WIN0) || (a == A_WIN1);
    endfunction

    function automatic access_t resolve(
        input addr_t a,
        input addr_t p0,
        input addr_t p1,
        input logic  bank,
        input addr_t b0_last,
        input addr_t b1_first,
        input addr_t b1_last
    );
        access_t r;
        addr_t   ea;
        logic    in_b1;
        logic    via_ptr;
        r       = '{tgt: TGT_NONE, off: '0};
        via_ptr = 1'b0;
        in_b1   = 1'b0;
        ea      = a;
        if (a == A_WIN0) begin
            ea      = p0;
            via_ptr = 1'b1;
        end else if (a == A_WIN1) begin
            ea      = p1;
            via_ptr = 1'b1;
            in_b1   = bank;
        end
        if (via_ptr && is_window(ea)) begin
            r.tgt = TGT_NONE;
        end else begin
            case (ea)
                A_PTR0: r.tgt = TGT_PTR0;
                A_PTR1: r.tgt = TGT_PTR1;
                A_BANK: r.tgt = TGT_BANK;
                A_ACC:  r.tgt = TGT_ACC;
                default: begin
                    if (!in_b1 && ea >= A_RAM0_FIRST && ea <= b0_last) begin
                        r.tgt = TGT_RAM0;
                        r.off = ea - A_RAM0_FIRST;
                    end else if (in_b1 && ea >= b1_first && ea <= b1_last) begin
                        r.tgt = TGT_RAM1;
                        r.off = ea - b1_first;
                    end
                end
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
    import dmem_pkg::*;
#(
    parameter addr_t B0_LAST  = 8'h7F,
    parameter addr_t B1_FIRST = 8'h41,
    parameter addr_t B1_LAST  = 8'h4B
) (
    input  addr_t   addr,
    input  addr_t   ptr0,
    input  addr_t   ptr1,
    input  logic    bank,
    output access_t acc_sel
);

    always_comb begin
        acc_sel = resolve(addr, ptr0, ptr1, bank, B0_LAST, B1_FIRST, B1_LAST);
    end

endmodule

// File: rtl/dmem_sysregs.sv
module dmem_sysregs
    import dmem_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  tgt_e  tgt,
    input  byte_t wd,
    output addr_t ptr0,
    output addr_t ptr1,
    output logic  bank,
    output byte_t acc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr0 <= '0;
            ptr1 <= '0;
            bank <= 1'b0;
            acc  <= '0;
        end else if (wr_en) begin
            case (tgt)
                TGT_PTR0: ptr0 <= wd;
                TGT_PTR1: ptr1 <= wd;
                TGT_BANK: bank <= wd[0];
                TGT_ACC:  acc  <= wd;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/dmem_ram.sv
module dmem_ram
    import dmem_pkg::*;
#(
    parameter addr_t BASE = 8'h06,
    parameter addr_t LAST = 8'h7F
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t off,
    input  byte_t wd,
    output byte_t rd
);

    localparam int COUNT = int'(LAST) - int'(BASE) + 1;
    localparam int IW    = (COUNT > 1) ? $clog2(COUNT) : 1;

    byte_t mem [COUNT];

    generate
        for (genvar i = 0; i < COUNT; i++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[i] <= '0;
                end else if (we && off == addr_t'(i)) begin
                    mem[i] <= wd;
                end
            end
        end
    endgenerate

    always_comb begin
        if (off < addr_t'(COUNT)) begin
            rd = mem[off[IW-1:0]];
        end else begin
            rd = '0;
        end
    end

endmodule

// File: rtl/dmem_bank_front.sv
module dmem_bank_front
    import dmem_pkg::*;
#(
    parameter addr_t B0_LAST  = 8'h7F,
    parameter addr_t B1_FIRST = 8'h41,
    parameter addr_t B1_LAST  = 8'h4B
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] addr,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [7:0] acc_out
);

    addr_t   ptr0_q;
    addr_t   ptr1_q;
    logic    bank_q;
    byte_t   acc_q;
    access_t sel;
    byte_t   ram0_rd;
    byte_t   ram1_rd;
    byte_t   rd_mux;

    dmem_decode #(
        .B0_LAST (B0_LAST),
        .B1_FIRST(B1_FIRST),
        .B1_LAST (B1_LAST)
    ) u_decode (
        .addr   (addr),
        .ptr0   (ptr0_q),
        .ptr1   (ptr1_q),
        .bank   (bank_q),
        .acc_sel(sel)
    );

    dmem_sysregs u_sys (
        .clk  (clk),
        .rst  (rst),
        .wr_en(wr_en),
        .tgt  (sel.tgt),
        .wd   (wr_data),
        .ptr0 (ptr0_q),
        .ptr1 (ptr1_q),
        .bank (bank_q),
        .acc  (acc_q)
    );

    dmem_ram #(
        .BASE(A_RAM0_FIRST),
        .LAST(B0_LAST)
    ) u_bank0 (
        .clk(clk),
        .rst(rst),
        .we (wr_en && sel.tgt == TGT_RAM0),
        .off(sel.off),
        .wd (wr_data),
        .rd (ram0_rd)
    );

    dmem_ram #(
        .BASE(B1_FIRST),
        .LAST(B1_LAST)
    ) u_bank1 (
        .clk(clk),
        .rst(rst),
        .we (wr_en && sel.tgt == TGT_RAM1),
        .off(sel.off),
        .wd (wr_data),
        .rd (ram1_rd)
    );

    always_comb begin
        case (sel.tgt)
            TGT_PTR0: rd_mux = ptr0_q;
            TGT_PTR1: rd_mux = ptr1_q;
            TGT_BANK: rd_mux = {7'b0, bank_q};
            TGT_ACC:  rd_mux = acc_q;
            TGT_RAM0: rd_mux = ram0_rd;
            TGT_RAM1: rd_mux = ram1_rd;
            default:  rd_mux = '0;
        endcase
    end

    assign rd_data = rd_en ? rd_mux : '0;
    assign acc_out = acc_q;

endmodule

// File: rtl/dmem_bank_front_chk.sv
module dmem_bank_front_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] addr,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [7:0] acc_out,
    input logic [7:0] ptr0,
    input logic [7:0] ptr1,
    input logic       bank
);

    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            AST_RESET_CLEARS: assert (acc_out == 8'h00 && ptr0 == 8'h00 && ptr1 == 8'h00 && bank == 1'b0); // R1
        end
    end

    AST_ACC_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h05) |=> (acc_out == $past(wr_data))); // R2

    AST_PTR0_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h01) |=> (ptr0 == $past(wr_data))); // R2

    AST_WIN0_SELF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 8'h00 && (ptr0 == 8'h00 || ptr0 == 8'h02)) |-> (rd_data == 8'h00)); // R8

    AST_WIN1_SELF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 8'h02 && (ptr1 == 8'h00 || ptr1 == 8'h02)) |-> (rd_data == 8'h00)); // R8

    AST_SELF_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ((addr == 8'h00 && (ptr0 == 8'h00 || ptr0 == 8'h02)) ||
                   (addr == 8'h02 && (ptr1 == 8'h00 || ptr1 == 8'h02))))
        |=> ($stable(acc_out) && $stable(ptr0) && $stable(ptr1) && $stable(bank))); // R8

    AST_WIN0_ACC_REACH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h00 && ptr0 == 8'h05) |=> (acc_out == $past(wr_data))); // R9

    AST_READ_GATED: assert property (@(posedge clk) disable iff (rst)
        (!rd_en) |-> (rd_data == 8'h00)); // R10

endmodule

bind dmem_bank_front dmem_bank_front_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .acc_out(acc_out),
    .ptr0   (ptr0_q),
    .ptr1   (ptr1_q),
    .bank   (bank_q)
);

// File: tb/dmem_bank_front_bench.sv
module dmem_bank_front_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] addr;
    logic       rd_en;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [7:0] acc_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dmem_bank_front u_dmem_bank_front (
        .clk    (clk),
        .rst    (rst),
        .addr   (addr),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .acc_out(acc_out)
    );

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        #1;
        d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'h01, v); chk("R1", "ptr0 after reset", v, 8'h00);
        rd(8'h03, v); chk("R1", "ptr1 after reset", v, 8'h00);
        rd(8'h04, v); chk("R1", "bank after reset", v, 8'h00);
        chk("R1", "acc after reset", acc_out, 8'h00);
        rd(8'h30, v); chk("R1", "bank0 word after reset", v, 8'h00);
    endtask

    task automatic t_direct_sys();
        logic [7:0] v;
        wr(8'h05, 8'hA5); chk("R2", "acc_out after write", acc_out, 8'hA5);
        rd(8'h05, v); chk("R2", "acc readback", v, 8'hA5);
        wr(8'h04, 8'hFE); rd(8'h04, v); chk("R2", "bank keeps bit0 only (FE)", v, 8'h00);
        wr(8'h04, 8'hFF); rd(8'h04, v); chk("R2", "bank keeps bit0 only (FF)", v, 8'h01);
        wr(8'h04, 8'h00);
        wr(8'h01, 8'h3A); rd(8'h01, v); chk("R2", "ptr0 readback", v, 8'h3A);
        wr(8'h03, 8'h6B); rd(8'h03, v); chk("R2", "ptr1 readback", v, 8'h6B);
    endtask

    task automatic t_bank0_ram();
        logic [7:0] v;
        wr(8'h06, 8'h11); wr(8'h7F, 8'h22); wr(8'h80, 8'h33); wr(8'hFF, 8'h44);
        rd(8'h06, v); chk("R3", "first bank0 word", v, 8'h11);
        rd(8'h7F, v); chk("R3", "last bank0 word", v, 8'h22);
        rd(8'h80, v); chk("R3", "80h unmapped", v, 8'h00);
        rd(8'hFF, v); chk("R3", "FFh unmapped", v, 8'h00);
    endtask

    task automatic t_win0();
        logic [7:0] v;
        wr(8'h20, 8'h5C);
        wr(8'h01, 8'h20);
        wr(8'h04, 8'h01);
        rd(8'h00, v); chk("R4", "window0 with bank=1 reads bank0", v, 8'h5C);
        wr(8'h00, 8'hC3);
        wr(8'h04, 8'h00);
        rd(8'h20, v); chk("R4", "window0 write lands in bank0", v, 8'hC3);
    endtask

    task automatic t_win1_banks();
        logic [7:0] v;
        wr(8'h41, 8'h55);
        wr(8'h03, 8'h41);
        wr(8'h04, 8'h01);
        rd(8'h02, v); chk("R6", "bank1 41h starts clear", v, 8'h00);
        wr(8'h02, 8'hAA);
        rd(8'h02, v); chk("R5", "window1 bank1 readback", v, 8'hAA);
        rd(8'h41, v); chk("R6", "direct 41h still bank0", v, 8'h55);
        wr(8'h04, 8'h00);
        rd(8'h02, v); chk("R5", "window1 bank0 reads 41h bank0", v, 8'h55);
        wr(8'h04, 8'h01);
        wr(8'h03, 8'h4B); wr(8'h02, 8'h9D);
        rd(8'h02, v); chk("R6", "bank1 last word 4Bh", v, 8'h9D);
        rd(8'h4B, v); chk("R6", "direct 4Bh is bank0", v, 8'h00);
        wr(8'h04, 8'h00);
    endtask

    task automatic t_bank1_reserved();
        logic [7:0] v;
        wr(8'h10, 8'h66);
        wr(8'h04, 8'h01);
        wr(8'h03, 8'h4C); wr(8'h02, 8'h77);
        rd(8'h02, v); chk("R7", "bank1 4Ch reserved", v, 8'h00);
        wr(8'h03, 8'h40); wr(8'h02, 8'h78);
        rd(8'h02, v); chk("R7", "bank1 40h reserved", v, 8'h00);
        wr(8'h03, 8'h10); wr(8'h02, 8'h79);
        rd(8'h02, v); chk("R7", "bank1 10h reserved", v, 8'h00);
        wr(8'h04, 8'h00);
        rd(8'h10, v); chk("R7", "bank0 10h untouched", v, 8'h66);
        rd(8'h40, v); chk("R7", "bank0 40h untouched", v, 8'h00);
    endtask

    task automatic t_self_window();
        logic [7:0] v;
        logic [7:0] acc_before;
        acc_before = acc_out;
        wr(8'h01, 8'h00); wr(8'h03, 8'h02);
        rd(8'h00, v); chk("R8", "window0 at 00h reads zero", v, 8'h00);
        rd(8'h02, v); chk("R8", "window1 at 02h reads zero", v, 8'h00);
        wr(8'h00, 8'h5A); wr(8'h02, 8'h5B);
        chk("R8", "acc unchanged by self write", acc_out, acc_before);
        rd(8'h01, v); chk("R8", "ptr0 unchanged", v, 8'h00);
        rd(8'h03, v); chk("R8", "ptr1 unchanged", v, 8'h02);
        rd(8'h04, v); chk("R8", "bank unchanged", v, 8'h00);
        wr(8'h01, 8'h02); wr(8'h04, 8'h01); wr(8'h03, 8'h00);
        rd(8'h00, v); chk("R8", "window0 at 02h reads zero", v, 8'h00);
        rd(8'h02, v); chk("R8", "window1 at 00h bank1 reads zero", v, 8'h00);
        wr(8'h04, 8'h00);
    endtask

    task automatic t_sys_via_ptr();
        logic [7:0] v;
        wr(8'h01, 8'h05); wr(8'h00, 8'h3C);
        chk("R9", "acc via window0", acc_out, 8'h3C);
        wr(8'h04, 8'h01);
        wr(8'h03, 8'h01); wr(8'h02, 8'h27);
        rd(8'h01, v); chk("R9", "ptr0 via window1 bank1", v, 8'h27);
        wr(8'h03, 8'h05);
        rd(8'h02, v); chk("R9", "acc read via window1 bank1", v, 8'h3C);
        wr(8'h03, 8'h04); wr(8'h02, 8'h00);
        rd(8'h04, v); chk("R9", "bank cleared via window1", v, 8'h00);
    endtask

    task automatic t_read_gate();
        @(negedge clk);
        addr = 8'h05; rd_en = 1'b0; wr_en = 1'b0;
        #1;
        chk("R10", "rd_en low gives zero", rd_data, 8'h00);
        @(negedge clk);
        addr = 8'h05; rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'hE1;
        #1;
        chk("R10", "same-cycle read returns old", rd_data, 8'h3C);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R10", "write visible after edge", rd_data, 8'hE1);
        rd_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1; addr = '0; rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct_sys();
        t_bank0_ram();
        t_win0();
        t_win1_banks();
        t_bank1_reserved();
        t_self_window();
        t_sys_via_ptr();
        t_read_gate();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule